// File: doc/BRIEF.md
# Multi-Lane ADC Serial Readout Shifter

This block serialises two channel results, A and B, onto four data lines during a readout frame. The frame is framed by an active-low chip select and clocked by an external serial clock. A host-side conversion path hands in each new pair of results with a one-cycle strobe. The block keeps the newest pair and the pair before it. When chip select falls, it loads one of the two pairs into its shift state, chosen by the latency setting. It then moves bits out on the serial clock edges that the selected SPI mode defines.

The lane setting chooses the layout. In the four-line layout, each channel uses two lines. In the two-line layout, each channel uses one line. In the shared layout, both channels go out back to back on a single line. Each line has a data value and a separate output-enable, so the pad ring can build the tri-state buffer. A line that the layout does not use is switched off, unless a keep-on input holds every line enabled. Line 0 can also repeat the incoming serial clock for the host to use as a timing reference.

The serial clock is treated as a level that the block clock samples. Its edges are found by comparing it with the value registered one cycle earlier. Each data line therefore moves one block-clock cycle after the serial-clock edge that shifts it.

Top module: `adcser_out_shift`

## Requirements
- R1: While reset is asserted, and until the first frame after it, every output-enable is 0 and every data line reads 0.
- R2: While `cs_n` is high, all four output-enables are 0 and all data lines read 0. This holds even with clock repeat or keep-on set.
- R3: Lane code 000 gives the four-line layout, 10 bits per line. Line 3 carries A bits 19,17,…,1 and line 2 carries A bits 18,16,…,0. Line 1 carries B bits 19,17,…,1 and line 0 carries B bits 18,…,0. Each line sends its bits in that order, most significant first.
- R4: Lane code 101 gives the two-line layout. Line 3 carries A bits 19 down to 0 and line 1 carries B bits 19 down to 0. Lines 2 and 0 are disabled unless keep-on is set.
- R5: Lane code 110 gives the shared layout. Line 3 carries A bits 19 down to 0 and then B bits 19 down to 0, over 40 clocks. Lines 2 to 0 are disabled unless keep-on is set.
- R6: Any other lane code gives the same layout as 000.
- R7: `spi_mode[1]` is the idle level of the serial clock. The leading edge leaves that level and the trailing edge returns to it. With `spi_mode[0]`=0, the first bit is on the lines once the frame has loaded, and each trailing edge moves to the next bit. With `spi_mode[0]`=1, the first leading edge keeps the first bit, and each later leading edge moves to the next bit.
- R8: With `low_latency`=0, a frame sends the pair stored before the newest one. With `low_latency`=1, it sends the newest pair.
- R9: With `sclk_echo`=1 and line 0 enabled, line 0 carries the level of `sclk` instead of data.
- R10: With `lines_keep_on`=1, all four lines are enabled during a frame. Lines that the layout does not use read 0.
- R11: Once all the bits of a line have been sent, further shift edges put 0 on that line.
- R12: The lane code and SPI mode are taken when `cs_n` falls. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples `cs_n` and `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a new result pair is present |
| smp_a | input | 20 | Channel A result |
| smp_b | input | 20 | Channel B result |
| lane_code | input | 3 | Layout select (000, 101, 110) |
| spi_mode | input | 2 | Bit 1 idle clock level, bit 0 shift phase |
| low_latency | input | 1 | 1 sends the newest pair, 0 the previous one |
| sclk_echo | input | 1 | Repeat `sclk` on line 0 |
| lines_keep_on | input | 1 | Keep all lines enabled during a frame |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock level |
| d_out | output | 4 | Data value of lines 3..0 |
| d_oe | output | 4 | Output-enable of lines 3..0 |

## Verification
Several properties are checked on every cycle:
- the lines stay quiet while chip select is high or reset is applied;
- lines that the two-line and shared layouts leave unused are disabled;
- the loaded pair is the one the latency setting picks;
- the shift state holds between serial-clock edges;
- line 0 follows the serial clock when clock repeat is on.

Other behaviour can only be seen across a whole frame, so the bench shows it:
- the bit order on each line;
- the even and odd split between the two lines of a channel;
- A coming before B on the shared line;
- the phase rules of all four SPI modes;
- the zero tail after the last bit;
- the settings taken at chip select fall being kept when the inputs change during the frame.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

    typedef enum logic [1:0] {
        LAY_QUAD   = 2'd0,
        LAY_DUAL   = 2'd1,
        LAY_SHARED = 2'd2
    } lane_layout_e;

    localparam logic [2:0] CODE_DUAL   = 3'b101;
    localparam logic [2:0] CODE_SHARED = 3'b110;

    function automatic lane_layout_e decode_layout(input logic [2:0] code);
        lane_layout_e lay;
        case (code)
            CODE_DUAL:   lay = LAY_DUAL;
            CODE_SHARED: lay = LAY_SHARED;
            default:     lay = LAY_QUAD;
        endcase
        return lay;
    endfunction

endpackage

// File: rtl/adcser_sample_store.sv
module adcser_sample_store #(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_a,
    input  logic [SAMPLE_W-1:0] smp_b,
    input  logic                low_latency,
    output logic [SAMPLE_W-1:0] sel_a,
    output logic [SAMPLE_W-1:0] sel_b
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] new_a;
        logic [SAMPLE_W-1:0] new_b;
        logic [SAMPLE_W-1:0] old_a;
        logic [SAMPLE_W-1:0] old_b;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            st_d.old_a = st_q.new_a;
            st_d.old_b = st_q.new_b;
            st_d.new_a = smp_a;
            st_d.new_b = smp_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_a = low_latency ? st_q.new_a : st_q.old_a;
    assign sel_b = low_latency ? st_q.new_b : st_q.old_b;

endmodule

// File: rtl/adcser_clk_edge.sv
module adcser_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cpol,
    input  logic cpha,
    input  logic live,
    input  logic load,
    output logic shift
);

    typedef struct packed {
        logic sclk;
        logic skip;
    } edge_t;

    edge_t st_d, st_q;
    logic  leading, trailing;

    assign leading  = (st_q.sclk == cpol) && (sclk != cpol);
    assign trailing = (st_q.sclk != cpol) && (sclk == cpol);
    assign shift    = live && (cpha ? (leading && !st_q.skip) : trailing);

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        if (load)                st_d.skip = 1'b1;
        else if (live && leading) st_d.skip = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adcser_lane_map.sv
module adcser_lane_map
    import adcser_pkg::*;
#(
    parameter int LANE_N = 4
) (
    input  lane_layout_e      layout,
    input  logic              live,
    input  logic              keep_on,
    input  logic              echo,
    input  logic              sclk,
    input  logic              a_hi,
    input  logic              a_lo,
    input  logic              b_hi,
    input  logic              b_lo,
    output logic [LANE_N-1:0] d_out,
    output logic [LANE_N-1:0] d_oe
);

    logic [LANE_N-1:0] used, raw, line_val;

    always_comb begin
        case (layout)
            LAY_DUAL: begin
                used = 4'b1010;
                raw  = {a_hi, 1'b0, b_hi, 1'b0};
            end
            LAY_SHARED: begin
                used = 4'b1000;
                raw  = {a_hi, 3'b000};
            end
            default: begin
                used = 4'b1111;
                raw  = {a_hi, a_lo, b_hi, b_lo};
            end
        endcase
    end

    assign d_oe = live ? (keep_on ? '1 : used) : '0;

    generate
        for (genvar g = 0; g < LANE_N; g++) begin : g_line
            if (g == 0) begin : g_echo
                assign line_val[g] = echo ? sclk : raw[g];
            end else begin : g_plain
                assign line_val[g] = raw[g];
            end
            assign d_out[g] = d_oe[g] & line_val[g];
        end
    endgenerate

endmodule

// File: rtl/adcser_out_shift.sv
module adcser_out_shift
    import adcser_pkg::*;
#(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_a,
    input  logic [SAMPLE_W-1:0] smp_b,
    input  logic [2:0]          lane_code,
    input  logic [1:0]          spi_mode,
    input  logic                low_latency,
    input  logic                sclk_echo,
    input  logic                lines_keep_on,
    input  logic                cs_n,
    input  logic                sclk,
    output logic [3:0]          d_out,
    output logic [3:0]          d_oe
);

    localparam int LANE_N = 4;
    localparam int PAIR_W = 2 * SAMPLE_W;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sr_a;
        logic [SAMPLE_W-1:0] sr_b;
        lane_layout_e        layout;
        logic                cpol;
        logic                cpha;
        logic                active;
        logic                cs;
    } shift_t;

    shift_t st_d, st_q;

    logic [SAMPLE_W-1:0] sel_a, sel_b;
    logic                cs_fall, live, shift_pulse;
    logic [PAIR_W-1:0]   pair_next;
    lane_layout_e        cur_layout;
    logic [SAMPLE_W-1:0] sr_a_q, sr_b_q;

    assign cs_fall    = st_q.cs && !cs_n;
    assign live       = st_q.active && !cs_n;
    assign cur_layout = st_q.layout;
    assign sr_a_q     = st_q.sr_a;
    assign sr_b_q     = st_q.sr_b;
    assign pair_next  = {st_q.sr_a, st_q.sr_b} << 1;

    adcser_sample_store #(.SAMPLE_W(SAMPLE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_a      (smp_a),
        .smp_b      (smp_b),
        .low_latency(low_latency),
        .sel_a      (sel_a),
        .sel_b      (sel_b)
    );

    adcser_clk_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .cpol (st_q.cpol),
        .cpha (st_q.cpha),
        .live (live),
        .load (cs_fall),
        .shift(shift_pulse)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cs = cs_n;
        if (cs_n) begin
            st_d.active = 1'b0;
        end else if (cs_fall) begin
            st_d.sr_a   = sel_a;
            st_d.sr_b   = sel_b;
            st_d.layout = decode_layout(lane_code);
            st_d.cpol   = spi_mode[1];
            st_d.cpha   = spi_mode[0];
            st_d.active = 1'b1;
        end else if (shift_pulse) begin
            case (st_q.layout)
                LAY_DUAL: begin
                    st_d.sr_a = st_q.sr_a << 1;
                    st_d.sr_b = st_q.sr_b << 1;
                end
                LAY_SHARED: begin
                    st_d.sr_a = pair_next[PAIR_W-1:SAMPLE_W];
                    st_d.sr_b = pair_next[SAMPLE_W-1:0];
                end
                default: begin
                    st_d.sr_a = st_q.sr_a << 2;
                    st_d.sr_b = st_q.sr_b << 2;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cs     <= 1'b1;
            st_q.layout <= LAY_QUAD;
        end else begin
            st_q <= st_d;
        end
    end

    adcser_lane_map #(.LANE_N(LANE_N)) u_map (
        .layout (st_q.layout),
        .live   (live),
        .keep_on(lines_keep_on),
        .echo   (sclk_echo),
        .sclk   (sclk),
        .a_hi   (st_q.sr_a[SAMPLE_W-1]),
        .a_lo   (st_q.sr_a[SAMPLE_W-2]),
        .b_hi   (st_q.sr_b[SAMPLE_W-1]),
        .b_lo   (st_q.sr_b[SAMPLE_W-2]),
        .d_out  (d_out),
        .d_oe   (d_oe)
    );

endmodule

// File: rtl/adcser_out_shift_chk.sv
module adcser_out_shift_chk
    import adcser_pkg::*;
#(
    parameter int SAMPLE_W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                sclk,
    input logic                echo,
    input logic                keep_on,
    input logic [3:0]          d_out,
    input logic [3:0]          d_oe,
    input logic                fall,
    input logic                shift,
    input lane_layout_e        layout,
    input logic [SAMPLE_W-1:0] sr_a,
    input logic [SAMPLE_W-1:0] sr_b,
    input logic [SAMPLE_W-1:0] sel_a,
    input logic [SAMPLE_W-1:0] sel_b
);

    always_comb begin
        if (rst_n == 1'b0) begin
            p_quiet_reset_r1: assert (d_oe == 4'b0000);
        end
    end

    p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (d_oe == 4'b0000));

    p_dual_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAY_DUAL && !keep_on) |-> (!d_oe[2] && !d_oe[0]));

    p_shared_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (layout == LAY_SHARED && !keep_on) |-> $onehot0(d_oe));

    p_hold_between_edges_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !shift) |=> ($stable(sr_a) && $stable(sr_b)));

    p_load_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (sr_a == $past(sel_a) && sr_b == $past(sel_b)));

    p_echo_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (echo && d_oe[0]) |-> (d_out[0] == sclk));

endmodule

bind adcser_out_shift adcser_out_shift_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .echo   (sclk_echo),
    .keep_on(lines_keep_on),
    .d_out  (d_out),
    .d_oe   (d_oe),
    .fall   (cs_fall),
    .shift  (shift_pulse),
    .layout (cur_layout),
    .sr_a   (sr_a_q),
    .sr_b   (sr_b_q),
    .sel_a  (sel_a),
    .sel_b  (sel_b)
);

// File: tb/test_adcser_out_shift.sv
module test_adcser_out_shift;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [19:0] smp_a = '0, smp_b = '0;
    logic [2:0]  lane_code = 3'b000;
    logic [1:0]  spi_mode = 2'b00;
    logic        low_latency = 1'b0, sclk_echo = 1'b0, lines_keep_on = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0;
    logic [3:0]  d_out, d_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    adcser_out_shift i_adcser_out_shift (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .lane_code(lane_code), .spi_mode(spi_mode), .low_latency(low_latency),
        .sclk_echo(sclk_echo), .lines_keep_on(lines_keep_on), .cs_n(cs_n), .sclk(sclk),
        .d_out(d_out), .d_oe(d_oe)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [1:0]  mode;
        logic        lowlat;
        logic [19:0] a;
        logic [19:0] b;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'b000, 2'd0, 1'b1, 20'hA5C3F, 20'h1E2D4},   // R3 R7
        '{3'b101, 2'd1, 1'b0, 20'h80001, 20'h7FFFE},   // R4 R7 R8
        '{3'b110, 2'd2, 1'b1, 20'hF0F0F, 20'h0F0F0},   // R5 R7
        '{3'b000, 2'd3, 1'b0, 20'h12345, 20'hFEDCB},   // R3 R7 R8
        '{3'b011, 2'd0, 1'b1, 20'h55AA3, 20'hC0FFE},   // R6
        '{3'b110, 2'd3, 1'b0, 20'h3C3C3, 20'hBEEF1}    // R5 R8
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int layout_of(input logic [2:0] code);
        if (code == 3'b101) return 1;
        if (code == 3'b110) return 2;
        return 0;
    endfunction

    function automatic int len_of(input int lay);
        return (lay == 0) ? 10 : (lay == 1) ? 20 : 40;
    endfunction

    function automatic logic [3:0] used_of(input int lay);
        return (lay == 0) ? 4'b1111 : (lay == 1) ? 4'b1010 : 4'b1000;
    endfunction

    function automatic logic get_bit(input int lay, input int line, input logic [19:0] a,
                                     input logic [19:0] b, input int i);
        if (i >= len_of(lay)) return 1'b0;
        if (lay == 0) begin
            case (line)
                3: return a[19-2*i];
                2: return a[18-2*i];
                1: return b[19-2*i];
                default: return b[18-2*i];
            endcase
        end
        if (lay == 1) begin
            if (line == 3) return a[19-i];
            if (line == 1) return b[19-i];
            return 1'b0;
        end
        if (line != 3) return 1'b0;
        return (i < 20) ? a[19-i] : b[39-i];
    endfunction

    function automatic logic [39:0] exp_word(input int lay, input int line, input logic [19:0] a,
                                             input logic [19:0] b, input int nbits);
        logic [39:0] w = '0;
        for (int i = 0; i < nbits; i++) w = {w[38:0], get_bit(lay, line, a, b, i)};
        return w;
    endfunction

    task automatic push(input logic [19:0] a, input logic [19:0] b);
        smp_a = a; smp_b = b; smp_valid = 1'b1;
        tick(1);
        smp_valid = 1'b0;
        tick(1);
    endtask

    task automatic run_frame(input logic [2:0] code, input logic [1:0] mode, input logic lowlat,
                             input logic keep, input logic [2:0] alt, input int nbits,
                             output logic [39:0] w3, output logic [39:0] w2,
                             output logic [39:0] w1, output logic [39:0] w0,
                             output logic [3:0] oe_and);
        w3 = '0; w2 = '0; w1 = '0; w0 = '0; oe_and = 4'hF;
        lane_code = code; spi_mode = mode; low_latency = lowlat; lines_keep_on = keep;
        sclk = mode[1];
        tick(3);
        cs_n = 1'b0;
        tick(3);
        lane_code = alt;
        for (int i = 0; i < nbits; i++) begin
            if (mode[0]) begin
                sclk = ~mode[1]; tick(3);
            end
            w3 = {w3[38:0], d_out[3]}; w2 = {w2[38:0], d_out[2]};
            w1 = {w1[38:0], d_out[1]}; w0 = {w0[38:0], d_out[0]};
            oe_and = oe_and & d_oe;
            if (mode[0]) begin
                sclk = mode[1]; tick(3);
            end else begin
                sclk = ~mode[1]; tick(3);
                sclk = mode[1];  tick(3);
            end
        end
        cs_n = 1'b1;
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [39:0] w3, w2, w1, w0;
        logic [3:0]  oe;
        tick(2);
        check_eq("R1 oe in reset", {36'd0, d_oe}, 40'd0);
        rst_n = 1'b1;
        tick(2);
        check_eq("R1 oe after reset", {36'd0, d_oe}, 40'd0);
        check_eq("R1 data after reset", {36'd0, d_out}, 40'd0);

        // Table walk: previous pair is the complement, newest pair is the vector
        for (int v = 0; v < 6; v++) begin
            automatic int lay = layout_of(VECS[v].code);
            automatic int nb  = len_of(lay);
            automatic logic [19:0] ea = VECS[v].lowlat ? VECS[v].a : ~VECS[v].a;
            automatic logic [19:0] eb = VECS[v].lowlat ? VECS[v].b : ~VECS[v].b;
            push(~VECS[v].a, ~VECS[v].b);
            push(VECS[v].a, VECS[v].b);
            run_frame(VECS[v].code, VECS[v].mode, VECS[v].lowlat, 1'b0, VECS[v].code, nb,
                      w3, w2, w1, w0, oe);
            check_eq($sformatf("R3 R4 R5 R6 R7 R8 line3 vec%0d", v), w3, exp_word(lay, 3, ea, eb, nb));
            check_eq($sformatf("R3 R4 R5 R6 R7 R8 line2 vec%0d", v), w2, exp_word(lay, 2, ea, eb, nb));
            check_eq($sformatf("R3 R4 R5 R6 R7 R8 line1 vec%0d", v), w1, exp_word(lay, 1, ea, eb, nb));
            check_eq($sformatf("R3 R4 R5 R6 R7 R8 line0 vec%0d", v), w0, exp_word(lay, 0, ea, eb, nb));
            check_eq($sformatf("R4 R5 enables vec%0d", v), {36'd0, oe}, {36'd0, used_of(lay)});
            check_eq($sformatf("R2 idle after vec%0d", v), {32'd0, d_oe, d_out}, 40'd0);
        end

        // R10: keep-on in two-line layout
        push(20'h11111, 20'h22222);
        push(20'hABCDE, 20'h13579);
        run_frame(3'b101, 2'd0, 1'b1, 1'b1, 3'b101, 20, w3, w2, w1, w0, oe);
        check_eq("R10 all enabled", {36'd0, oe}, 40'hF);
        check_eq("R10 line2 zero", w2, 40'd0);
        check_eq("R10 line0 zero", w0, 40'd0);
        check_eq("R10 line3 data", w3, exp_word(1, 3, 20'hABCDE, 20'h13579, 20));

        // R12: lane code changed to shared during a four-line frame
        run_frame(3'b000, 2'd0, 1'b1, 1'b0, 3'b110, 10, w3, w2, w1, w0, oe);
        check_eq("R12 line3 kept", w3, exp_word(0, 3, 20'hABCDE, 20'h13579, 10));
        check_eq("R12 line0 kept", w0, exp_word(0, 0, 20'hABCDE, 20'h13579, 10));

        // R11: four extra edges give zeros
        run_frame(3'b000, 2'd1, 1'b1, 1'b0, 3'b000, 14, w3, w2, w1, w0, oe);
        check_eq("R11 line3 tail", w3, exp_word(0, 3, 20'hABCDE, 20'h13579, 14));
        check_eq("R11 line0 tail", w0, exp_word(0, 0, 20'hABCDE, 20'h13579, 14));

        // R9: clock repeat on line 0, then R2 with repeat still on
        sclk_echo = 1'b1; lane_code = 3'b000; spi_mode = 2'd0; sclk = 1'b0;
        tick(3);
        check_eq("R2 echo idle", {36'd0, d_oe}, 40'd0);
        cs_n = 1'b0; tick(3);
        sclk = 1'b1; tick(1);
        check_eq("R9 echo high", {39'd0, d_out[0]}, 40'd1);
        sclk = 1'b0; tick(1);
        check_eq("R9 echo low", {39'd0, d_out[0]}, 40'd0);
        sclk = 1'b1; tick(1);
        check_eq("R9 echo high again", {39'd0, d_out[0]}, 40'd1);
        cs_n = 1'b1; tick(2);
        check_eq("R2 echo cs high", {32'd0, d_oe, d_out}, 40'd0);
        sclk_echo = 1'b0; sclk = 1'b0;
        tick(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule